// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit with Signed Compare

This block is a purely combinational arithmetic logic unit for a processor datapath. It is built by repeating a one-bit slice across the operand width. Every slice holds an AND gate, an OR gate and a full adder, and all three always evaluate. A small per-slice multiplexer picks which of them drives the result bit. Carries ripple from slice to slice, starting at bit 0.

A two-bit operation select and a single operand-negate line together choose the operation. The supported operations are bitwise AND, bitwise OR, addition, subtraction, signed set-on-less-than and equality. Subtraction reuses the adder: the negate line complements every b bit and also enters as the carry into bit 0. Set-on-less-than also subtracts, then routes the sign of the top slice's sum back into bit 0. Equality has no result of its own; it is read from the zero flag after a subtraction.

Top module: `slice_alu`

## Requirements
- R1: With op_sel = 0 and b_neg = 0, result equals opnd_a AND opnd_b, bit by bit.
- R2: With op_sel = 1 and b_neg = 0, result equals opnd_a OR opnd_b, bit by bit.
- R3: With op_sel = 2 and b_neg = 0, {carry_out, result} equals the WIDTH+1-bit unsigned sum opnd_a + opnd_b.
- R4: With op_sel = 2 and b_neg = 1:
  - result equals opnd_a - opnd_b modulo 2^WIDTH;
  - carry_out is 1 exactly when opnd_a >= opnd_b as unsigned numbers.
- R5: With op_sel = 3 and b_neg = 1:
  - result bits WIDTH-1 down to 1 are 0;
  - result bit 0 is the most significant bit of opnd_a - opnd_b modulo 2^WIDTH. When no signed overflow occurs, this equals opnd_a < opnd_b as signed numbers.
- R6: zero is 1 exactly when every bit of result is 0. With op_sel = 2 and b_neg = 1, zero is therefore 1 exactly when opnd_a equals opnd_b.
- R7: ovf is 1 when the two adder inputs have the same sign bit and the sum's sign bit differs from it. The adder inputs are opnd_a and opnd_b, or the complement of opnd_b when b_neg = 1. This gives signed overflow of addition (b_neg = 0) and of subtraction (b_neg = 1).
- R8: b_neg = 1 complements opnd_b in every slice for all operations. With op_sel = 0 result is opnd_a AND NOT opnd_b, and with op_sel = 1 it is opnd_a OR NOT opnd_b.
- R9: carry_out and ovf come from the always-active adder for every op_sel value. With op_sel = 0, 1 or 3 they equal the values the same operands and b_neg produce under op_sel = 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, complemented when b_neg is 1 |
| op_sel | input | 2 | Operation: 0 AND, 1 OR, 2 add/subtract, 3 set-on-less-than |
| b_neg | input | 1 | Complement opnd_b and carry 1 into bit 0 |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the top slice |
| ovf | output | 1 | Signed overflow of the adder |
| zero | output | 1 | 1 when result is all zeros |

## Verification
The hardest case to reach is set-on-less-than when the subtraction overflows. There, the routed sign bit disagrees with the true signed comparison. The stimulus reaches it by pairing the most negative and most positive operands in both orders, and by sweeping every operand pair of a 4-bit instance. That sweep also drives every op_sel and b_neg combination, so the "unused" ones, such as AND with a complemented b, are covered. Equal operands are placed deliberately so that the zero flag rises under subtraction.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_OR  = 2'd1,
    OP_ADD = 2'd2,
    OP_SLT = 2'd3
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_bit,
  input  logic    b_bit,
  input  logic    cin,
  input  logic    b_neg,
  input  logic    less_in,
  input  alu_op_e op,
  output logic    res_bit,
  output logic    cout,
  output logic    sum_bit
);
  logic b_eff;
  logic and_v;
  logic or_v;

  assign b_eff   = b_bit ^ b_neg;
  assign and_v   = a_bit & b_eff;
  assign or_v    = a_bit | b_eff;
  assign sum_bit = a_bit ^ b_eff ^ cin;
  assign cout    = (a_bit & b_eff) | (a_bit & cin) | (b_eff & cin);

  always_comb begin
    unique case (op)
      OP_AND:  res_bit = and_v;
      OP_OR:   res_bit = or_v;
      OP_ADD:  res_bit = sum_bit;
      default: res_bit = less_in;
    endcase
  end
endmodule

// File: rtl/alu_zero_flag.sv
module alu_zero_flag #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  assign is_zero = ~(|value);
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       op_sel,
  input  logic             b_neg,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sums;
  logic             set_bit;

  assign op       = alu_op_e'(op_sel);
  assign carry[0] = b_neg;
  assign set_bit  = sums[MSB];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_w;
    if (i == 0) begin : g_lsb
      assign less_w = set_bit;
    end else begin : g_upper
      assign less_w = 1'b0;
    end
    alu_slice u_slice (
      .a_bit   (opnd_a[i]),
      .b_bit   (opnd_b[i]),
      .cin     (carry[i]),
      .b_neg   (b_neg),
      .less_in (less_w),
      .op      (op),
      .res_bit (result[i]),
      .cout    (carry[i+1]),
      .sum_bit (sums[i])
    );
  end

  assign carry_out = carry[WIDTH];
  assign ovf       = carry[MSB] ^ carry[WIDTH];

  alu_zero_flag #(.WIDTH(WIDTH)) u_zero (
    .value   (result),
    .is_zero (zero)
  );

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_sel, b_neg})) begin
      if (op_sel == 2'd0 && !b_neg)
        p_and_r1: assert (result == (opnd_a & opnd_b));
      if (op_sel == 2'd1 && !b_neg)
        p_or_r2: assert (result == (opnd_a | opnd_b));
      if (op_sel == 2'd2 && !b_neg)
        p_add_r3: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
      if (op_sel == 2'd2 && b_neg)
        p_sub_r4: assert (result == opnd_a - opnd_b && carry_out == (opnd_a >= opnd_b));
      if (op_sel == 2'd3 && b_neg)
        p_slt_r5: assert (result[MSB:1] == '0 &&
                          (ovf || result[0] == ($signed(opnd_a) < $signed(opnd_b))));
      if (op_sel == 2'd2 && b_neg)
        p_equal_r6: assert (zero == (opnd_a == opnd_b));
      if (op_sel == 2'd2 && !b_neg)
        p_add_ovf_r7: assert (ovf == ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])));
      if (op_sel == 2'd0 && b_neg)
        p_and_not_r8: assert (result == (opnd_a & ~opnd_b));
    end
  end
endmodule

// File: tb/slice_alu_test.sv
module slice_alu_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [31:0] a32 = '0, b32 = '0, r32;
  logic [1:0]  op32 = '0;
  logic        bn32 = 1'b0, c32, v32, z32;
  logic [3:0]  a4 = '0, b4 = '0, r4;
  logic [1:0]  op4 = '0;
  logic        bn4 = 1'b0, c4, v4, z4;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  slice_alu #(.WIDTH(32)) uut (
    .opnd_a(a32), .opnd_b(b32), .op_sel(op32), .b_neg(bn32),
    .result(r32), .carry_out(c32), .ovf(v32), .zero(z32)
  );

  slice_alu #(.WIDTH(4)) uut_small (
    .opnd_a(a4), .opnd_b(b4), .op_sel(op4), .b_neg(bn4),
    .result(r4), .carry_out(c4), .ovf(v4), .zero(z4)
  );

  task automatic one(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic compare(int w, logic [31:0] a, logic [31:0] b, logic [1:0] op,
                         logic bn, logic [31:0] gr, logic gc, logic gv, logic gz);
    logic [63:0] mask, bb, full, sum, er;
    logic ec, ev, ez, sa, sb, ss;
    string rtag;
    mask = (64'd1 << w) - 64'd1;
    bb   = bn ? (~{32'd0, b} & mask) : {32'd0, b};
    full = {32'd0, a} + bb + {63'd0, bn};
    sum  = full & mask;
    ec   = full[w];
    sa   = a[w-1];
    sb   = bb[w-1];
    ss   = sum[w-1];
    ev   = (sa == sb) && (ss != sa);
    case (op)
      2'd0:    begin er = {32'd0, a} & bb; rtag = bn ? "R8" : "R1"; end
      2'd1:    begin er = {32'd0, a} | bb; rtag = bn ? "R8" : "R2"; end
      2'd2:    begin er = sum;             rtag = bn ? "R4" : "R3"; end
      default: begin er = {63'd0, ss};     rtag = "R5"; end
    endcase
    ez = (er == 64'd0);
    one($sformatf("%s result w=%0d op=%0d bn=%0d a=%h b=%h", rtag, w, op, bn, a, b),
        {32'd0, gr}, er);
    one($sformatf("%s carry w=%0d op=%0d bn=%0d", (op == 2'd2) ? (bn ? "R4" : "R3") : "R9",
        w, op, bn), {63'd0, gc}, {63'd0, ec});
    one($sformatf("%s ovf w=%0d op=%0d bn=%0d", (op == 2'd2) ? "R7" : "R9", w, op, bn),
        {63'd0, gv}, {63'd0, ev});
    one($sformatf("R6 zero w=%0d op=%0d bn=%0d", w, op, bn), {63'd0, gz}, {63'd0, ez});
  endtask

  task automatic run32(logic [31:0] a, logic [31:0] b, logic [1:0] op, logic bn);
    @(posedge clk);
    #1;
    a32 = a; b32 = b; op32 = op; bn32 = bn;
    @(negedge clk);
    compare(32, a32, b32, op32, bn32, r32, c32, v32, z32);
  endtask

  task automatic run4(logic [3:0] a, logic [3:0] b, logic [1:0] op, logic bn);
    @(posedge clk);
    #1;
    a4 = a; b4 = b; op4 = op; bn4 = bn;
    @(negedge clk);
    compare(4, {28'd0, a4}, {28'd0, b4}, op4, bn4, {28'd0, r4}, c4, v4, z4);
  endtask

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000;
    corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000;
    corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: quiet inputs give an all-zero result and a raised zero flag
    one("R6 idle result", {32'd0, r32}, 64'd0);
    one("R6 idle zero", {63'd0, z32}, 64'd1);
    // exhaustive sweep of the 4-bit configuration, every op and negate setting
    for (int op = 0; op < 4; op++)
      for (int bn = 0; bn < 2; bn++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            run4(4'(a), 4'(b), 2'(op), 1'(bn));
    // R5 overflow corner: most negative minus most positive, and reverse
    run32(32'h8000_0000, 32'h7FFF_FFFF, 2'd3, 1'b1);
    run32(32'h7FFF_FFFF, 32'h8000_0000, 2'd3, 1'b1);
    // corner operand pairs at full width
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int op = 0; op < 4; op++)
          for (int bn = 0; bn < 2; bn++)
            run32(corner[i], corner[j], 2'(op), 1'(bn));
    // R6 equality: equal random operands under subtraction
    for (int k = 0; k < 40; k++) begin
      logic [31:0] x;
      x = $urandom;
      run32(x, x, 2'd2, 1'b1);
    end
    // random operands across all modes
    for (int k = 0; k < 400; k++)
      run32($urandom, $urandom, 2'($urandom), 1'($urandom));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule